// File: doc/BRIEF.md
# Dual-Mode 16-bit Multiply-Accumulate Lane

This block is the multiply-accumulate datapath for one arithmetic lane of a DSP core. Each of its two 32-bit source operands carries a signed high 16-bit half and a signed low 16-bit half. Two 16x16 signed multipliers work side by side. One forms the product of the two high halves and the other forms the product of the two low halves. A 40-bit accumulator value comes in with the operands, and a 2-bit opcode chooses how the products are folded into it.

There are four opcodes:
- **Single:** only the high-half product is added to the 40-bit accumulator.
- **Dual:** both products are added to the 40-bit accumulator.
- **Split:** the accumulator is treated as two isolated 20-bit lanes, with the high-half product going to the upper lane and the low-half product to the lower lane.
- **Pass:** the accumulator is returned unchanged.

Operands are taken on a valid strobe. The result and its valid flag are registered and appear on the next clock edge. The surrounding core owns register files, decode, saturation and rounding, so this block never saturates: all sums wrap.

Top module: `dual_mac_lane`

## Requirements
- R1: While `rst_n` is low at a rising edge, `out_valid` is 0 and `result` is 0 after that edge.
- R2: `out_valid` is 1 after a rising edge exactly when `in_valid` was 1 at that edge, so every result appears one cycle after its operands.
- R3: With `op` = 2'b00, `result` = `acc_in` + sign-extended(`src_a[31:16]` * `src_b[31:16]`) modulo 2^40. The low halves `src_a[15:0]` and `src_b[15:0]` have no effect on the result.
- R4: With `op` = 2'b01, `result` = `acc_in` + sext(`src_a[31:16]`*`src_b[31:16]`) + sext(`src_a[15:0]`*`src_b[15:0]`) modulo 2^40.
- R5: With `op` = 2'b10, `result[39:20]` = `acc_in[39:20]` + high-half product modulo 2^20, and `result[19:0]` = `acc_in[19:0]` + low-half product modulo 2^20. No carry or borrow crosses bit 20.
- R6: With `op` = 2'b11, `result` equals `acc_in`.
- R7: When `in_valid` is 0 at a rising edge, `result` keeps its previous value.
- R8: All halves are signed two's complement. For example, -32768 * -32768 contributes +2^30.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op | input | 2 | 00 single, 01 dual, 10 split 20-bit lanes, 11 pass |
| src_a | input | 32 | First source: signed high half [31:16], signed low half [15:0] |
| src_b | input | 32 | Second source, same layout as `src_a` |
| acc_in | input | 40 | Accumulator value to add to |
| out_valid | output | 1 | `result` holds a new value |
| result | output | 40 | Registered accumulated result |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid timing and reset clearing;
- that `result` holds while the strobe is low;
- that pass mode returns the accumulator;
- that split mode with a zero first operand leaves both lanes untouched.

Only the bench scenarios can show the arithmetic itself. That covers signed products at the extreme values, 40-bit wraparound, the absence of a carry between the split lanes when the lower lane overflows, and that low halves do not affect single mode.

// File: rtl/dual_mac_pkg.sv
// Package: shared opcode type for the dual-mode MAC lane.
// Assumes a 2-bit opcode field whose encoding is fixed by the core's decoder.
package dual_mac_pkg;
    typedef enum logic [1:0] {
        MAC_OP_SINGLE = 2'b00,
        MAC_OP_DUAL   = 2'b01,
        MAC_OP_SPLIT  = 2'b10,
        MAC_OP_PASS   = 2'b11
    } mac_op_e;
endpackage

// File: rtl/mac_mul_signed.sv
// Module: signed HALF_W x HALF_W multiplier producing a full-width product.
// Assumes both operands are two's complement; purely combinational.
module mac_mul_signed #(
    parameter int HALF_W = 16,
    localparam int PROD_W = 2 * HALF_W
) (
    input  logic [HALF_W-1:0] mul_x,
    input  logic [HALF_W-1:0] mul_y,
    output logic [PROD_W-1:0] mul_p
);
    // Form the exact signed product.
    always_comb begin
        mul_p = PROD_W'($signed(mul_x) * $signed(mul_y));
    end
endmodule

// File: rtl/mac_fold.sv
// Module: folds two signed products into an accumulator according to opcode.
// Assumes ACC_W is even and at least PROD_W; all sums wrap, no saturation.
module mac_fold
    import dual_mac_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int ACC_W  = 40,
    localparam int PROD_W = 2 * HALF_W,
    localparam int LANE_W = ACC_W / 2
) (
    input  mac_op_e            fold_op,
    input  logic [PROD_W-1:0]  prod_hi,
    input  logic [PROD_W-1:0]  prod_lo,
    input  logic [ACC_W-1:0]   acc_val,
    output logic [ACC_W-1:0]   fold_sum
);
    logic [ACC_W-1:0]  ext_hi;
    logic [ACC_W-1:0]  ext_lo;
    logic [LANE_W-1:0] lane_up;
    logic [LANE_W-1:0] lane_dn;

    // Sign-extend both products to the accumulator width.
    always_comb begin
        ext_hi = {{(ACC_W-PROD_W){prod_hi[PROD_W-1]}}, prod_hi};
        ext_lo = {{(ACC_W-PROD_W){prod_lo[PROD_W-1]}}, prod_lo};
    end

    // Compute the two isolated lane sums used by split mode.
    always_comb begin
        lane_up = acc_val[ACC_W-1:LANE_W] + ext_hi[LANE_W-1:0];
        lane_dn = acc_val[LANE_W-1:0]     + ext_lo[LANE_W-1:0];
    end

    // Select the final sum by opcode.
    always_comb begin
        unique case (fold_op)
            MAC_OP_SINGLE: fold_sum = acc_val + ext_hi;
            MAC_OP_DUAL:   fold_sum = acc_val + ext_hi + ext_lo;
            MAC_OP_SPLIT:  fold_sum = {lane_up, lane_dn};
            default:       fold_sum = acc_val;
        endcase
    end
endmodule

// File: rtl/dual_mac_lane.sv
// Module: one DSP lane MAC with two 16x16 multipliers sharing a 40-bit accumulator.
// Assumes operands are stable while in_valid is high; result is registered one cycle later.
module dual_mac_lane
    import dual_mac_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int ACC_W  = 40,
    localparam int SRC_W  = 2 * HALF_W,
    localparam int PROD_W = 2 * HALF_W,
    localparam int N_MUL  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op,
    input  logic [SRC_W-1:0]  src_a,
    input  logic [SRC_W-1:0]  src_b,
    input  logic [ACC_W-1:0]  acc_in,
    output logic              out_valid,
    output logic [ACC_W-1:0]  result
);
    logic [PROD_W-1:0] prod [N_MUL];
    logic [ACC_W-1:0]  sum_next;

    // Index 0 multiplies the low halves, index 1 the high halves.
    for (genvar gi = 0; gi < N_MUL; gi++) begin : g_mul
        mac_mul_signed #(.HALF_W(HALF_W)) u_mul (
            .mul_x(src_a[gi*HALF_W +: HALF_W]),
            .mul_y(src_b[gi*HALF_W +: HALF_W]),
            .mul_p(prod[gi])
        );
    end

    mac_fold #(.HALF_W(HALF_W), .ACC_W(ACC_W)) u_fold (
        .fold_op (mac_op_e'(op)),
        .prod_hi (prod[1]),
        .prod_lo (prod[0]),
        .acc_val (acc_in),
        .fold_sum(sum_next)
    );

    // Register the valid flag, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Capture the result on a strobe, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)        result <= '0;
        else if (in_valid) result <= sum_next;
    end
endmodule

// File: rtl/dual_mac_lane_chk.sv
// Module: protocol checker for dual_mac_lane, attached by bind.
// Assumes the same parameters as the checked instance.
module dual_mac_lane_chk #(
    parameter int HALF_W = 16,
    parameter int ACC_W  = 40,
    localparam int SRC_W = 2 * HALF_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       op,
    input logic [SRC_W-1:0] src_a,
    input logic [SRC_W-1:0] src_b,
    input logic [ACC_W-1:0] acc_in,
    input logic             out_valid,
    input logic [ACC_W-1:0] result
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_pass_through_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b11) |=> result == $past(acc_in));

    assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    assert_split_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b10 && src_a == '0 && src_b != '0) |=> result == $past(acc_in));
endmodule

bind dual_mac_lane dual_mac_lane_chk #(.HALF_W(HALF_W), .ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .src_a(src_a),
    .src_b(src_b), .acc_in(acc_in), .out_valid(out_valid), .result(result)
);

// File: tb/dual_mac_lane_tb_top.sv
`timescale 1ns/1ps
module dual_mac_lane_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [39:0] acc_in = '0;
    logic        out_valid;
    logic [39:0] result;

    int n_tests = 0;
    int n_fail  = 0;
    logic [39:0] last_seen = '0;

    typedef struct {
        logic [39:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #4 clk = ~clk;

    dual_mac_lane dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .src_a(src_a),
        .src_b(src_b), .acc_in(acc_in), .out_valid(out_valid), .result(result)
    );

    // Independent model derived from the requirements.
    function automatic logic [39:0] model(logic [1:0] m, logic [31:0] a, logic [31:0] b,
                                          logic [39:0] acc);
        int ph;
        int pl;
        logic [39:0] eh;
        logic [39:0] el;
        logic [19:0] up;
        logic [19:0] dn;
        ph = int'($signed(a[31:16])) * int'($signed(b[31:16]));
        pl = int'($signed(a[15:0]))  * int'($signed(b[15:0]));
        eh = 40'(longint'(ph));
        el = 40'(longint'(pl));
        up = acc[39:20] + eh[19:0];
        dn = acc[19:0]  + el[19:0];
        case (m)
            2'b00:   return acc + eh;
            2'b01:   return acc + eh + el;
            2'b10:   return {up, dn};
            default: return acc;
        endcase
    endfunction

    task automatic check(string tag, logic [39:0] got, logic [39:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Driver: apply one operation for one cycle and queue its expectation.
    task automatic drive(string tag, logic [1:0] m, logic [31:0] a, logic [31:0] b,
                         logic [39:0] acc, logic [39:0] exp_override = 'x,
                         bit use_override = 0);
        sb_item_t it;
        @(negedge clk);
        in_valid = 1'b1; op = m; src_a = a; src_b = b; acc_in = acc;
        it.exp = use_override ? exp_override : model(m, a, b, acc);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            src_a = $urandom; src_b = $urandom; acc_in = {8'h5a, 32'($urandom)};
        end
    endtask

    // Monitor: compare each produced result against the queue head.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                n_tests++; n_fail++;
                $display("FAIL R2: unexpected out_valid, got %h expected none", result);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(it.tag, result, it.exp);
            end
            last_seen = result;
        end
    end

    // Watchdog.
    initial begin
        #400000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", {39'b0, out_valid}, 40'd0);
        check("R1 result", result, 40'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 single mode, with low halves varied to show they are ignored
        drive("R3 single basic", 2'b00, 32'h0003_1234, 32'h0005_7777, 40'd100);
        drive("R3 low halves ignored", 2'b00, 32'h0003_0000, 32'h0005_ffff, 40'd100, 40'd115, 1);
        drive("R3 negative product", 2'b00, 32'hfffe_0001, 32'h0007_0001, 40'd10);
        drive("R3 40-bit wrap", 2'b00, 32'h0001_0000, 32'h0001_0000, 40'hff_ffff_ffff, 40'd0, 1);
        // R8 signed extremes
        drive("R8 min*min", 2'b00, 32'h8000_0000, 32'h8000_0000, 40'd0, 40'h00_4000_0000, 1);
        drive("R8 min*max", 2'b00, 32'h8000_0000, 32'h7fff_0000, 40'd0, 40'hff_c000_8000, 1);
        // R4 dual mode
        drive("R4 dual basic", 2'b01, 32'h0002_0003, 32'h0004_0005, 40'd1, 40'd24, 1);
        drive("R4 dual mixed signs", 2'b01, 32'hffff_0010, 32'h0100_0010, 40'd0, 40'd0, 1);
        drive("R4 dual extremes", 2'b01, 32'h8000_8000, 32'h8000_8000, 40'd0, 40'h00_8000_0000, 1);
        idle(2);
        // R5 split mode
        drive("R5 split basic", 2'b10, 32'h0003_0002, 32'h0004_0005, 40'h00010_00020,
              40'h0001c_0002a, 1);
        drive("R5 lower wrap no carry", 2'b10, 32'h0000_0001, 32'h0000_0001, 40'h00000_fffff,
              40'h00000_00000, 1);
        drive("R5 upper wrap", 2'b10, 32'h0001_0000, 32'h0001_0000, 40'hfffff_00005,
              40'h00000_00005, 1);
        drive("R5 negative borrow isolated", 2'b10, 32'h0000_ffff, 32'h0000_0001, 40'h00007_00000,
              40'h00007_fffff, 1);
        drive("R5 random", 2'b10, 32'h1234_8765, 32'h4321_9abc, 40'h12_3456_789a);
        // R6 pass
        drive("R6 pass", 2'b11, 32'hffff_ffff, 32'h7fff_7fff, 40'h9a_bcde_f012, 40'h9a_bcde_f012, 1);
        // R7 hold while idle
        idle(4);
        n_tests++;
        if (result !== 40'h9a_bcde_f012 || out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R7: got %h/%b expected %h/0", result, out_valid, 40'h9a_bcde_f012);
        end
        // R2 back-to-back random traffic
        for (int i = 0; i < 40; i++) begin
            drive("R2 stream", 2'($urandom), $urandom, $urandom, {8'($urandom), 32'($urandom)});
        end
        idle(3);
        check("R2 queue drained", 40'(sb_q.size()), 40'd0);
        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset again", result, 40'd0);
        check("R1 valid again", {39'b0, out_valid}, 40'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule